// File: doc/BRIEF.md
# Word-Stride Gray Address Generator

This block produces the program-fetch address for a processor that fetches whole words. Sequential fetches make up most of the address traffic, so the address leaves the block in a Gray-style encoding in which each sequential advance toggles exactly one address line. That cuts switching activity on a heavily loaded address bus. The stride is a parameter: 1 for byte machines, 4 for 32-bit words, 8 for 64-bit words.

With k = log2(STRIDE), the encoded address is the reflected Gray code of the word index (address >> k) placed above the reflected Gray code of the k byte-offset bits. A sequential step changes only the word index, so only one line changes. A jump or branch is not computed in the Gray domain. Instead, the caller presents the binary target with a load strobe. The block holds a binary counter, derives the encoding from the counter's next value, and registers both. Both forms of the address are available at the outputs.

Top module: `gray_stride_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, both outputs become zero after that edge, whatever `load_i` and `step_i` are doing.
- R2: After an edge with `load_i` high, `bin_addr_o` equals the `target_i` value sampled at that edge, and `gray_addr_o` holds its encoding.
- R3: When `load_i` and `step_i` are both high, the load takes effect and the step is discarded.
- R4: After an edge with only `step_i` high, `bin_addr_o` equals its previous value plus STRIDE, modulo 2^ADDR_W.
- R5: After an edge with only `step_i` high, `gray_addr_o` differs from its previous value in exactly one bit.
- R6: With neither strobe high, both outputs keep their values.
- R7: With STRIDE = 1, addresses 0 to 8 encode as 0000, 0001, 0011, 0010, 0110, 0111, 0101, 0100, 1100 in the low four bits.
- R8: With STRIDE = 4, addresses 0 to 8 encode as 0000, 0001, 0011, 0010, 0100, 0101, 0111, 0110, 1100. The two low bits are the Gray code of the byte offset, and the bits above them are the Gray code of address >> 2.
- R9: With STRIDE = 8, addresses 0 to 8 encode as 0000, 0001, 0011, 0010, 0110, 0111, 0101, 0100, 1000.
- R10: A step from the last word of the address space wraps `bin_addr_o` to the byte offset alone, and the encoded address still changes in one bit.
- R11: Steps never alter the low k bits of a target that is not word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load the binary target (jump) |
| target_i | input | ADDR_W | Binary jump or start address |
| step_i | input | 1 | Advance by one word |
| gray_addr_o | output | ADDR_W | Registered encoded address |
| bin_addr_o | output | ADDR_W | Registered binary address |

## Verification
The bench builds three copies of the block with ADDR_W = 16 and STRIDE set to 4, 1 and 8. It loads each address from 0 to 8 into all three copies, which brings every published encoding within reach in one pass. The stride-4 copy is also driven through step runs, hold cycles and a load colliding with a step. Using 16 bits also puts the top-of-range wrap within reach after a single load near 0xFFF8.

// File: rtl/gray_addr_pkg.sv
package gray_addr_pkg;

  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_LOAD = 2'd1,
    UPD_STEP = 2'd2
  } upd_e;

  // number of byte-offset bits below the word index
  function automatic int unsigned offset_bits(input int unsigned stride);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 8; i++) begin
      if ((32'd1 << i) < stride) n = i + 1;
    end
    return n;
  endfunction

endpackage

// File: rtl/gray_conv.sv
module gray_conv #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] gray_o
);
  assign gray_o = bin_i ^ (bin_i >> 1);
endmodule

// File: rtl/stride_gray_encoder.sv
module stride_gray_encoder #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned K      = 2
) (
  input  logic [ADDR_W-1:0] bin_i,
  output logic [ADDR_W-1:0] enc_o
);
  localparam int unsigned HI_W = ADDR_W - K;

  logic [HI_W-1:0] hi_gray;

  gray_conv #(.W(HI_W)) u_hi (
    .bin_i  (bin_i[ADDR_W-1:K]),
    .gray_o (hi_gray)
  );

  generate
    if (K > 0) begin : g_off
      logic [K-1:0] lo_gray;
      gray_conv #(.W(K)) u_lo (
        .bin_i  (bin_i[K-1:0]),
        .gray_o (lo_gray)
      );
      assign enc_o = {hi_gray, lo_gray};
    end else begin : g_nooff
      assign enc_o = hi_gray;
    end
  endgenerate
endmodule

// File: rtl/addr_word_counter.sv
module addr_word_counter
  import gray_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned K      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  upd_e              cmd_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] bin_next_o,
  output logic [ADDR_W-1:0] bin_q_o
);
  localparam int unsigned HI_W = ADDR_W - K;

  logic [ADDR_W-1:0] bin_q;
  logic [HI_W-1:0]   word_inc;

  assign word_inc = bin_q[ADDR_W-1:K] + HI_W'(1);

  always_comb begin
    bin_next_o = bin_q;
    case (cmd_i)
      UPD_LOAD: bin_next_o = target_i;
      UPD_STEP: bin_next_o[ADDR_W-1:K] = word_inc;
      default:  bin_next_o = bin_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bin_q <= '0;
    else     bin_q <= bin_next_o;
  end

  assign bin_q_o = bin_q;

  generate
    if (K > 0) begin : g_off_chk
      // R11
      offset_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == UPD_STEP) |=> bin_q[K-1:0] == $past(bin_q[K-1:0]));
    end
  endgenerate
endmodule

// File: rtl/gray_stride_addr_gen.sv
module gray_stride_addr_gen
  import gray_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] gray_addr_o,
  output logic [ADDR_W-1:0] bin_addr_o
);
  localparam int unsigned K = offset_bits(STRIDE);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STRIDE);

  upd_e              cmd;
  logic [ADDR_W-1:0] bin_next;
  logic [ADDR_W-1:0] enc_next;
  logic [ADDR_W-1:0] gray_q;

  always_comb begin
    if (load_i)      cmd = UPD_LOAD;
    else if (step_i) cmd = UPD_STEP;
    else             cmd = UPD_HOLD;
  end

  addr_word_counter #(.ADDR_W(ADDR_W), .K(K)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .cmd_i      (cmd),
    .target_i   (target_i),
    .bin_next_o (bin_next),
    .bin_q_o    (bin_addr_o)
  );

  stride_gray_encoder #(.ADDR_W(ADDR_W), .K(K)) u_enc (
    .bin_i (bin_next),
    .enc_o (enc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) gray_q <= '0;
    else     gray_q <= enc_next;
  end

  assign gray_addr_o = gray_q;

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> bin_addr_o == $past(target_i));

  // R3
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && step_i) |=> bin_addr_o == $past(target_i));

  // R4
  stride_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i) |=> bin_addr_o == $past(bin_addr_o) + STEP_V);

  // R5
  one_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i) |=> $countones(gray_addr_o ^ $past(gray_addr_o)) == 1);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !load_i) |=> ($stable(gray_addr_o) && $stable(bin_addr_o)));
endmodule

// File: tb/gray_stride_addr_gen_tb.sv
module gray_stride_addr_gen_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst, load, step;
  logic [W-1:0] target;
  logic [W-1:0] g4, b4, g1, b1, g8, b8;

  gray_stride_addr_gen #(.ADDR_W(W), .STRIDE(4)) u_dut (
    .clk(clk), .rst(rst), .load_i(load), .target_i(target), .step_i(step),
    .gray_addr_o(g4), .bin_addr_o(b4));
  gray_stride_addr_gen #(.ADDR_W(W), .STRIDE(1)) u_s1 (
    .clk(clk), .rst(rst), .load_i(load), .target_i(target), .step_i(step),
    .gray_addr_o(g1), .bin_addr_o(b1));
  gray_stride_addr_gen #(.ADDR_W(W), .STRIDE(8)) u_s8 (
    .clk(clk), .rst(rst), .load_i(load), .target_i(target), .step_i(step),
    .gray_addr_o(g8), .bin_addr_o(b8));

  typedef struct {
    logic [W-1:0] b;
    logic [W-1:0] g;
    bit           seq;
    string        req;
  } item_t;

  item_t        q[$];
  int           checks = 0;
  int           fails  = 0;
  logic [W-1:0] model_b;
  logic [W-1:0] last_g;

  logic [3:0] t1 [9] = '{4'h0, 4'h1, 4'h3, 4'h2, 4'h6, 4'h7, 4'h5, 4'h4, 4'hC};
  logic [3:0] t4 [9] = '{4'h0, 4'h1, 4'h3, 4'h2, 4'h4, 4'h5, 4'h7, 4'h6, 4'hC};
  logic [3:0] t8 [9] = '{4'h0, 4'h1, 4'h3, 4'h2, 4'h6, 4'h7, 4'h5, 4'h4, 4'h8};

  function automatic logic [W-1:0] enc(input logic [W-1:0] v, input int k);
    logic [W-1:0] hi, lo;
    hi = v >> k;
    lo = v & ((W'(1) << k) - W'(1));
    return ((hi ^ (hi >> 1)) << k) | (lo ^ (lo >> 1));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input bit ld, input logic [W-1:0] tgt, input bit st,
                       input string req);
    @(negedge clk);
    load = ld; target = tgt; step = st;
    if (ld)      model_b = tgt;
    else if (st) model_b = model_b + W'(4);
    @(posedge clk);
    #1;
    q.push_back('{b: model_b, g: enc(model_b, 2), seq: (!ld && st), req: req});
  endtask

  // monitor: compares stride-4 outputs one cycle after each driven edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(b4 == it.b, it.req, "binary address", b4, it.b);
      check(g4 == it.g, it.req, "encoded address", g4, it.g);
      if (it.seq)
        check($countones(g4 ^ last_g) == 1, "R5", "one-bit change", g4 ^ last_g, '0);
      last_g = g4;
    end
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; load = 1'b1; step = 1'b1; target = 16'hFFFF;
    model_b = '0; last_g = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset dominates the strobes
    check(b4 == '0 && g4 == '0, "R1", "stride4 reset", g4, '0);
    check(b1 == '0 && g8 == '0, "R1", "stride1/8 reset", b1 | g8, '0);
    rst = 1'b0; load = 1'b0; step = 1'b0;

    // R7 R8 R9: encoding tables, loaded into all three copies
    for (int v = 0; v < 9; v++) begin
      drive(1'b1, W'(v), 1'b0, "R2");
      check(g1[3:0] == t1[v], "R7", "stride1 table", W'(g1[3:0]), W'(t1[v]));
      check(g4[3:0] == t4[v], "R8", "stride4 table", W'(g4[3:0]), W'(t4[v]));
      check(g8[3:0] == t8[v], "R9", "stride8 table", W'(g8[3:0]), W'(t8[v]));
    end

    // R4 R5: run of sequential steps
    drive(1'b1, 16'h0100, 1'b0, "R2");
    for (int i = 0; i < 6; i++) drive(1'b0, '0, 1'b1, "R4");

    // R6: idle cycles hold both outputs
    drive(1'b0, 16'h5555, 1'b0, "R6");
    drive(1'b0, 16'hAAAA, 1'b0, "R6");

    // R3: load and step together
    drive(1'b1, 16'h2002, 1'b1, "R3");
    check(b4 == 16'h2002, "R3", "load over step", b4, 16'h2002);

    // R11: unaligned target keeps its offset across steps
    for (int i = 0; i < 3; i++) drive(1'b0, '0, 1'b1, "R11");
    check(b4[1:0] == 2'b10, "R11", "offset bits", W'(b4[1:0]), W'(2'b10));

    // R10: wrap at the top of the range
    drive(1'b1, 16'hFFF8, 1'b0, "R2");
    drive(1'b0, '0, 1'b1, "R10");
    drive(1'b0, '0, 1'b1, "R10");
    check(b4 == '0, "R10", "wrap to zero", b4, '0);
    drive(1'b0, '0, 1'b1, "R10");

    drive(1'b0, '0, 1'b0, "R6");
    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule